// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes charge of the command, address, bank, clock-enable and byte-mask pins of a four-bank, 16-bit-wide synchronous DRAM from reset until the memory is ready for use. It steps through a fixed bring-up order, and each step has its own counted wait:

- a long idle period at power-up;
- a close-all-banks precharge;
- a configurable number of auto-refresh commands;
- a mode-register load;
- a short idle tail.

When the sequence is complete it raises a ready flag, and an access controller can then take over the bus.

Commands are encoded on the active-low chip-select, row-strobe, column-strobe and write-enable pins in that order, {cs_n, ras_n, cas_n, we_n}:

| Command | Encoding |
|---|---|
| NOP | 0111 |
| PRECHARGE | 0010 |
| AUTO REFRESH | 0001 |
| LOAD MODE | 0000 |

All outputs come from registered state, so the memory samples stable values on the next rising edge of the shared clock. The idle periods are parameters given in clock cycles. The power-up wait should cover at least 100 µs at the clock rate in use, which is 20000 cycles at 200 MHz. The refresh count is forced to at least 2 and the trailing idle count to at least 2. The other waits are forced to at least 1.

Top module: `sdram_boot_seq`

## Requirements
- R1: During the first PWR_CYCLES cycles after reset is released, the block drives NOP (0111) and ready is low.
- R2: CKE is high and every DQM bit is high in every cycle after reset.
- R3: In cycle PWR_CYCLES after release, the block issues PRECHARGE (0010) with address bit 10 high, so that all banks close. It then issues exactly RP_NOPS NOP cycles.
- R4: The block next issues REFRESH_COUNT AUTO REFRESH commands (0001), each followed by exactly RFC_NOPS NOP cycles.
- R5: LOAD MODE (0000) comes only after the last refresh wait. It drives MODE_WORD on the 12 address bits and 00 on the bank bits.
- R6: After LOAD MODE the block drives exactly MRD_NOPS NOP cycles with ready low. In the following cycle ready goes high.
- R7: Once ready is high, it stays high and the command stays NOP until the next reset.
- R8: A synchronous reset at any point in the sequence drives NOP with ready low, and the sequence restarts from the power-up wait.
- R9: The address and bank outputs are zero in every cycle other than PRECHARGE and LOAD MODE. During PRECHARGE only bit 10 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W (12) | Address bus; carries A10 for precharge-all and the mode value |
| sd_bank | output | BANK_W (2) | Bank select |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | DQM_W (2) | Byte masks, held high |
| ready | output | 1 | High once initialization is complete |

## Verification
The bench uses a small configuration with uneven waits and three refreshes, so that the per-step counts cannot be confused with one another. For every cycle, it compares the full pin state against a timeline computed arithmetically from the parameters. It first runs the whole sequence from reset. It then sweeps a reset across every cycle offset of the sequence, from the very first idle cycle through the ready state. These runs distinguish an off-by-one in any single wait, a lost or extra refresh, and a reset that fails to restart the count from any intermediate state. A long dwell after ready shows whether the flag and the NOP output stay put.

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq #(
  parameter int          PWR_CYCLES    = 20000,
  parameter int          RP_NOPS       = 3,
  parameter int          RFC_NOPS      = 13,
  parameter int          REFRESH_COUNT = 2,
  parameter int          MRD_NOPS      = 2,
  parameter int          ADDR_W        = 12,
  parameter int          BANK_W        = 2,
  parameter int          DQM_W         = 2,
  parameter logic [11:0] MODE_WORD     = 12'h030
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_bank,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              ready
);
  localparam int PWR_N = (PWR_CYCLES    > 1) ? PWR_CYCLES    : 1;
  localparam int RP_N  = (RP_NOPS       > 1) ? RP_NOPS       : 1;
  localparam int RFC_N = (RFC_NOPS      > 1) ? RFC_NOPS      : 1;
  localparam int REF_N = (REFRESH_COUNT > 2) ? REFRESH_COUNT : 2;
  localparam int MRD_N = (MRD_NOPS      > 2) ? MRD_NOPS      : 2;
  localparam int MAX_A = (PWR_N > RP_N)  ? PWR_N : RP_N;
  localparam int MAX_B = (RFC_N > MRD_N) ? RFC_N : MRD_N;
  localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_W + 1);
  localparam int RW    = $clog2(REF_N + 1);

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_LOAD = 4'b0000;

  typedef enum logic [2:0] {
    S_WAIT_PWR, S_PRECHARGE, S_WAIT_RP, S_REFRESH,
    S_WAIT_RFC, S_LOAD_MODE, S_WAIT_MRD, S_DONE
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs;
  logic [3:0]    cmd;
  wire           cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_WAIT_PWR;
      cnt   <= CW'(PWR_N - 1);
      refs  <= '0;
    end else begin
      case (state)
        S_WAIT_PWR: if (cnt_zero) state <= S_PRECHARGE; else cnt <= cnt - 1'b1;
        S_PRECHARGE: begin
          state <= S_WAIT_RP;
          cnt   <= CW'(RP_N - 1);
        end
        S_WAIT_RP: if (cnt_zero) state <= S_REFRESH; else cnt <= cnt - 1'b1;
        S_REFRESH: begin
          state <= S_WAIT_RFC;
          cnt   <= CW'(RFC_N - 1);
          refs  <= refs + 1'b1;
        end
        S_WAIT_RFC:
          if (cnt_zero) state <= (refs == RW'(REF_N)) ? S_LOAD_MODE : S_REFRESH;
          else cnt <= cnt - 1'b1;
        S_LOAD_MODE: begin
          state <= S_WAIT_MRD;
          cnt   <= CW'(MRD_N - 1);
        end
        S_WAIT_MRD: if (cnt_zero) state <= S_DONE; else cnt <= cnt - 1'b1;
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    cmd     = C_NOP;
    sd_addr = '0;
    sd_bank = '0;
    case (state)
      S_PRECHARGE: begin
        cmd         = C_PRE;
        sd_addr[10] = 1'b1;
      end
      S_REFRESH: cmd = C_REF;
      S_LOAD_MODE: begin
        cmd     = C_LOAD;
        sd_addr = ADDR_W'(MODE_WORD);
      end
      default: cmd = C_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke = 1'b1;
  assign sd_dqm = '1;
  assign ready  = (state == S_DONE);

  logic [RW-1:0] seen_refs;
  always_ff @(posedge clk) begin
    if (rst) seen_refs <= '0;
    else if (cmd == C_REF && seen_refs != RW'(REF_N)) seen_refs <= seen_refs + 1'b1;
  end

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_PRE) |-> (sd_addr[10] && !ready));
  p_load_after_refs_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_LOAD) |-> (seen_refs == RW'(REF_N) && sd_bank == '0));
  p_nop_after_load_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_LOAD) |=> (cmd == C_NOP && !ready));
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ready && cmd == C_NOP));
  p_no_ref_before_pre_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF && seen_refs == '0) |-> $past(cmd) == C_NOP);
endmodule

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;
  localparam int          P    = 6;
  localparam int          RP   = 2;
  localparam int          RFC  = 3;
  localparam int          REFS = 3;
  localparam int          MRD  = 2;
  localparam logic [11:0] MODE = 12'h5A3;
  localparam int          TDONE = P + 1 + RP + REFS * (1 + RFC) + 1 + MRD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n, ras_n, cas_n, we_n, cke, rdy;
  logic [11:0] addr;
  logic [1:0]  bank, dqm;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_boot_seq #(
    .PWR_CYCLES(P), .RP_NOPS(RP), .RFC_NOPS(RFC), .REFRESH_COUNT(REFS),
    .MRD_NOPS(MRD), .MODE_WORD(MODE)
  ) i_sdram_boot_seq (
    .clk(clk), .rst(rst), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_addr(addr), .sd_bank(bank), .sd_cke(cke),
    .sd_dqm(dqm), .ready(rdy)
  );

  function automatic void expect_at(input int t, output logic [3:0] c,
                                    output logic [11:0] a, output logic r,
                                    output string q);
    int u;
    c = 4'b0111; a = 12'h000; r = 1'b0; q = "R1";
    if (t < P) q = "R1";
    else if (t == P) begin c = 4'b0010; a = 12'h400; q = "R3"; end
    else if (t <= P + RP) q = "R3";
    else begin
      u = t - (P + 1 + RP);
      if (u < REFS * (1 + RFC)) begin
        q = "R4";
        if (u % (1 + RFC) == 0) c = 4'b0001;
      end else begin
        u = u - REFS * (1 + RFC);
        if (u == 0) begin c = 4'b0000; a = MODE; q = "R5"; end
        else if (u <= MRD) q = "R6";
        else begin r = 1'b1; q = "R7"; end
      end
    end
  endfunction

  task automatic check_cycle(input int t);
    logic [3:0] ec; logic [11:0] ea; logic er; string q;
    expect_at(t, ec, ea, er, q);
    n_chk++;
    if (cke !== 1'b1 || dqm !== 2'b11) begin
      n_bad++;
      $display("FAIL R2 t=%0d cke/dqm=%b/%b expected 1/11", t, cke, dqm);
    end
    n_chk++;
    if ({cs_n, ras_n, cas_n, we_n} !== ec || rdy !== er) begin
      n_bad++;
      $display("FAIL %s t=%0d cmd/ready=%b/%b expected %b/%b", q, t,
               {cs_n, ras_n, cas_n, we_n}, rdy, ec, er);
    end
    n_chk++;
    if (addr !== ea || bank !== 2'b00) begin
      n_bad++;
      $display("FAIL %s R9 t=%0d addr/bank=%h/%b expected %h/00", q, t, addr, bank, ea);
    end
  endtask

  task automatic run_after_reset(input int n, input string tag);
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    n_chk++;
    if ({cs_n, ras_n, cas_n, we_n} !== 4'b0111 || rdy !== 1'b0) begin
      n_bad++;
      $display("FAIL %s in reset cmd/ready=%b/%b expected 0111/0", tag,
               {cs_n, ras_n, cas_n, we_n}, rdy);
    end
    rst = 1'b0;
    for (int t = 0; t < n; t++) begin
      check_cycle(t);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    run_after_reset(TDONE + 40, "R1");
    for (int k = 0; k <= TDONE + 2; k++) run_after_reset(k, "R8");
    run_after_reset(TDONE + 5, "R8");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule